// File: doc/BRIEF.md
# Pixel Serial Stream Decoder

The decoder takes one serial pixel-module stream, one bit per qualified clock, and turns each event into a series of 32-bit words for the next formatting stage. While idle it looks for a five-bit event header and accepts it even when one bit is wrong. It then expects every later field to open with a sync bit of value 1, followed by eight data bits: first the level-1 trigger number, then the bunch-crossing number, then a series of tagged items. An item tag selects a module-controller flag, a front-end chip number, a front-end error flag, the row of a hit (followed by sixteen untagged bits holding column and time-over-threshold), or the end of the event. Each hit becomes its own word.

A zero where a sync bit belongs, or a tag that is not allowed at that point, makes the decoder stop interpreting the stream. It then packs the following bits into raw words of sixteen bits until it sees the exact nine-bit trailer `1_0000_0000`. The idle line must sit at 0. When the downstream buffer reports almost full, only header and trailer words are written. A mask input holds the decoder in idle and discards the stream.

States: `S_IDLE` (header search), `S_L1`, `S_BC`, `S_POST_BC`, `S_POST_MCC`, `S_POST_FE`, `S_POST_HIT`, `S_POST_FLAG` (sync-plus-byte field states), `S_HIT_TAIL` (column and time bits) and `S_RAW`. Transitions: idle to L1 on a header match. L1 to BC, and BC to post-BC, on a complete field. Post-BC goes to post-MCC on a module flag. Post-BC or post-MCC goes to post-FE on a chip number. Post-FE goes to post-flag on an error flag, or to hit-tail on a row tag. Hit-tail goes to post-hit. Post-hit goes on to hit-tail, post-FE or post-flag. Post-flag goes to post-FE. Post-hit and post-flag return to idle on the end tag. Any field state goes to raw on a missing sync bit or a disallowed tag. Raw goes to idle on the exact trailer. Any state goes to idle while masked.

Top module: `psd_decoder`

## Requirements
- R1: In `S_IDLE`, a header is recognised when the last five bits differ from `11101` (first-received bit leftmost) in at most one position. The header word `0x00000000` (type 000 in bits [31:29]) then appears one cycle after the last header bit, and the decoder moves to `S_L1`.
- R2: A five-bit window that differs from `11101` in two or more positions produces no word, and the decoder stays idle.
- R3: Each field is a sync bit of 1 followed by eight bits, most significant first. The first field after the header gives word `{3'b001, 21'b0, byte}` and the second gives `{3'b010, 21'b0, byte}`. Every word appears in the cycle after the bit that completes it.
- R4: After the second field, a tag with upper nibble `D` yields a module flag word `{3'b101, 1'b1, 24'b0, tag[3:0]}`, after which only a chip-number tag is accepted. A tag with upper nibble `E` yields a chip word `{3'b011, 25'b0, tag[3:0]}` and sets the current chip number.
- R5: After a chip number or a hit, a tag in the range `0x01` to `0xCF` is a hit row. The next sixteen bits are column then time-over-threshold, and the hit word is `{3'b100, 1'b0, chip[3:0], row, column, tot}`. After a hit, another hit, a chip number, an error flag or the end tag may follow.
- R6: After a chip number or a hit, a tag with upper nibble `F` yields an error flag word `{3'b101, 1'b0, chip[3:0], 20'b0, tag[3:0]}`. After it, a chip number or the end tag may follow.
- R7: A 0 in a sync-bit position moves the decoder to `S_RAW`, and `raw_mode_o` goes high in the next cycle. Every sixteen following bits give a raw word `{3'b110, 13'b0, bits}` with the first-received bit in bit 15.
- R8: Raw mode ends only on an exact match of the last nine bits with `1_0000_0000`. A pattern differing in one bit does not end it.
- R9: The end tag `0x00` (in `S_POST_HIT` or `S_POST_FLAG`) and the raw-mode trailer both write the word `0xE0000000` (type 111). `trailer_written_o` is high in exactly that cycle, and `raw_mode_o` is low from that cycle on.
- R10: While `almost_full_i` is high in the cycle that completes a word, only header and trailer words are written. Other words are dropped, but decoding continues.
- R11: Cycles with `bit_en_i` low have no effect. While `mask_i` is high no word is written, the stream is ignored and the decoder returns to `S_IDLE`.
- R12: A tag not allowed in the current state, such as the end tag straight after the second field, moves the decoder to `S_RAW` like a missing sync bit.
- R13: After reset `word_valid_o`, `trailer_written_o` and `raw_mode_o` are low and the decoder is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_i | input | 1 | Disables decoding and forces idle |
| bit_en_i | input | 1 | Qualifies `bit_i` in this cycle |
| bit_i | input | 1 | Serial stream bit |
| almost_full_i | input | 1 | Downstream buffer nearly full |
| word_o | output | 32 | Output word, type in bits [31:29] |
| word_valid_o | output | 1 | Write strobe for `word_o` |
| trailer_written_o | output | 1 | High with the trailer word |
| raw_mode_o | output | 1 | High while in raw pass-through |

## Verification
The bench sends headers with one wrong bit in different positions. A decoder that matched exactly would lose those events, and one that allowed two errors would start on noise. In raw mode it sends a one-bit-off trailer before the real one: a decoder with a tolerant trailer match would end raw mode early and misframe the next event. Raw words straddling the trailer check that the sixteen-bit packing and the trailer test run side by side. It also checks hits with extreme row values (0x01, 0xCF), a chip change after a hit, the end tag after a flag, an end tag where it is not allowed, almost-full gating, enable gaps inside fields and a mask applied mid-event. A wrong counter reload or transition shows up as a word one cycle early or late, or with the wrong type code.

// File: rtl/psd_pkg.sv
package psd_pkg;

    localparam int WORD_W  = 32;
    localparam int TYPE_W  = 3;
    localparam int PL_W    = WORD_W - TYPE_W;
    localparam int FIELD_W = 8;
    localparam int RAW_W   = 16;
    localparam int NIB_W   = FIELD_W / 2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_L1,
        S_BC,
        S_POST_BC,
        S_POST_MCC,
        S_POST_FE,
        S_POST_HIT,
        S_POST_FLAG,
        S_HIT_TAIL,
        S_RAW
    } state_e;

    localparam logic [TYPE_W-1:0] T_HDR  = 3'd0;
    localparam logic [TYPE_W-1:0] T_L1   = 3'd1;
    localparam logic [TYPE_W-1:0] T_BC   = 3'd2;
    localparam logic [TYPE_W-1:0] T_FE   = 3'd3;
    localparam logic [TYPE_W-1:0] T_HIT  = 3'd4;
    localparam logic [TYPE_W-1:0] T_FLAG = 3'd5;
    localparam logic [TYPE_W-1:0] T_RAW  = 3'd6;
    localparam logic [TYPE_W-1:0] T_TRL  = 3'd7;

    localparam logic [NIB_W-1:0]   NIB_MCC  = 4'hD;
    localparam logic [NIB_W-1:0]   NIB_FE   = 4'hE;
    localparam logic [NIB_W-1:0]   NIB_FLAG = 4'hF;
    localparam logic [FIELD_W-1:0] TAG_END  = 8'h00;

    typedef struct packed {
        state_e                nxt;
        logic                  emit;
        logic [TYPE_W-1:0]     wtype;
        logic [PL_W-1:0]       pl;
        logic                  ld_fe;
        logic                  ld_row;
    } tag_res_t;

    function automatic logic is_hit_tag(input logic [FIELD_W-1:0] t);
        return (t != TAG_END) && (t[FIELD_W-1 -: NIB_W] < NIB_MCC);
    endfunction

    // Classify one completed field byte in the given field state.
    function automatic tag_res_t decode_tag(input state_e st,
                                            input logic [FIELD_W-1:0] t,
                                            input logic [NIB_W-1:0] fe);
        tag_res_t r;
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
        logic is_mcc, is_fe, is_flag, is_end, is_hit;
        hi      = t[FIELD_W-1 -: NIB_W];
        lo      = t[NIB_W-1:0];
        is_mcc  = (hi == NIB_MCC);
        is_fe   = (hi == NIB_FE);
        is_flag = (hi == NIB_FLAG);
        is_end  = (t == TAG_END);
        is_hit  = is_hit_tag(t);
        r.nxt    = S_RAW;
        r.emit   = 1'b0;
        r.wtype  = T_RAW;
        r.pl     = '0;
        r.ld_fe  = 1'b0;
        r.ld_row = 1'b0;
        unique case (st)
            S_L1: begin
                r.nxt = S_BC; r.emit = 1'b1; r.wtype = T_L1; r.pl = PL_W'(t);
            end
            S_BC: begin
                r.nxt = S_POST_BC; r.emit = 1'b1; r.wtype = T_BC; r.pl = PL_W'(t);
            end
            S_POST_BC: begin
                if (is_mcc) begin
                    r.nxt = S_POST_MCC; r.emit = 1'b1; r.wtype = T_FLAG;
                    r.pl = {1'b1, {(PL_W-1-NIB_W){1'b0}}, lo};
                end else if (is_fe) begin
                    r.nxt = S_POST_FE; r.emit = 1'b1; r.wtype = T_FE;
                    r.pl = PL_W'(lo); r.ld_fe = 1'b1;
                end
            end
            S_POST_MCC: begin
                if (is_fe) begin
                    r.nxt = S_POST_FE; r.emit = 1'b1; r.wtype = T_FE;
                    r.pl = PL_W'(lo); r.ld_fe = 1'b1;
                end
            end
            S_POST_FE, S_POST_HIT: begin
                if (is_end && st == S_POST_HIT) begin
                    r.nxt = S_IDLE; r.emit = 1'b1; r.wtype = T_TRL;
                end else if (is_fe && st == S_POST_HIT) begin
                    r.nxt = S_POST_FE; r.emit = 1'b1; r.wtype = T_FE;
                    r.pl = PL_W'(lo); r.ld_fe = 1'b1;
                end else if (is_flag) begin
                    r.nxt = S_POST_FLAG; r.emit = 1'b1; r.wtype = T_FLAG;
                    r.pl = {1'b0, fe, {(PL_W-1-2*NIB_W){1'b0}}, lo};
                end else if (is_hit) begin
                    r.nxt = S_HIT_TAIL; r.ld_row = 1'b1;
                end
            end
            S_POST_FLAG: begin
                if (is_end) begin
                    r.nxt = S_IDLE; r.emit = 1'b1; r.wtype = T_TRL;
                end else if (is_fe) begin
                    r.nxt = S_POST_FE; r.emit = 1'b1; r.wtype = T_FE;
                    r.pl = PL_W'(lo); r.ld_fe = 1'b1;
                end
            end
            default: r.nxt = S_RAW;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/psd_pattern_match.sv
module psd_pattern_match #(
    parameter int             LEN     = 5,
    parameter logic [LEN-1:0] PAT     = '0,
    parameter int             MAX_ERR = 0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic hit_o
);

    logic [LEN-1:0] sr_q;
    logic [LEN-1:0] window;

    assign window = {sr_q[LEN-2:0], bit_i};

    generate
        if (MAX_ERR == 0) begin : g_exact
            assign hit_o = shift_i && (window == PAT);
        end else begin : g_tolerant
            logic [LEN-1:0] diff;
            assign diff  = window ^ PAT;
            assign hit_o = shift_i && ($countones(diff) <= MAX_ERR);
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sr_q <= '0;
        else if (clr_i)   sr_q <= '0;
        else if (shift_i) sr_q <= window;
    end

endmodule

// File: rtl/psd_shift_collect.sv
module psd_shift_collect #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] nxt_o
);

    logic [W-1:0] sr_q;

    assign nxt_o = {sr_q[W-2:0], bit_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sr_q <= '0;
        else if (shift_i) sr_q <= nxt_o;
    end

endmodule

// File: rtl/psd_decoder.sv
module psd_decoder
    import psd_pkg::*;
#(
    parameter int                 HDR_LEN     = 5,
    parameter logic [HDR_LEN-1:0] HDR_PAT     = 5'b11101,
    parameter int                 HDR_MAX_ERR = 1,
    parameter int                 TRL_LEN     = 9,
    parameter logic [TRL_LEN-1:0] TRL_PAT     = 9'b1_0000_0000
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        mask_i,
    input  logic        bit_en_i,
    input  logic        bit_i,
    input  logic        almost_full_i,
    output logic [31:0] word_o,
    output logic        word_valid_o,
    output logic        trailer_written_o,
    output logic        raw_mode_o
);

    localparam int COLL_W = (RAW_W > 2*FIELD_W) ? RAW_W : 2*FIELD_W;
    localparam int CNT_W  = $clog2(COLL_W + 1);
    localparam logic [CNT_W-1:0] FIELD_LAST = CNT_W'(FIELD_W);
    localparam logic [CNT_W-1:0] TAIL_LAST  = CNT_W'(2*FIELD_W - 1);
    localparam logic [CNT_W-1:0] RAW_LAST   = CNT_W'(RAW_W - 1);

    state_e             st_q, st_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [NIB_W-1:0]   fe_q, fe_d;
    logic [FIELD_W-1:0] row_q, row_d;

    logic               adv;
    logic               hdr_hit, trl_hit;
    logic [COLL_W-1:0]  coll_nxt;
    logic [FIELD_W-1:0] tag;
    tag_res_t           tr;

    logic               emit;
    logic [TYPE_W-1:0]  emit_t;
    logic [PL_W-1:0]    emit_pl;

    logic [WORD_W-1:0]  word_q;
    logic               valid_q, trl_q;

    assign adv = bit_en_i && !mask_i;
    assign tag = coll_nxt[FIELD_W-1:0];

    psd_pattern_match #(
        .LEN(HDR_LEN), .PAT(HDR_PAT), .MAX_ERR(HDR_MAX_ERR)
    ) u_hdr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (mask_i || (st_q != S_IDLE)),
        .shift_i(adv && (st_q == S_IDLE)),
        .bit_i  (bit_i),
        .hit_o  (hdr_hit)
    );

    psd_pattern_match #(
        .LEN(TRL_LEN), .PAT(TRL_PAT), .MAX_ERR(0)
    ) u_trl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (mask_i || (st_q != S_RAW)),
        .shift_i(adv && (st_q == S_RAW)),
        .bit_i  (bit_i),
        .hit_o  (trl_hit)
    );

    psd_shift_collect #(.W(COLL_W)) u_coll (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .shift_i(adv),
        .bit_i  (bit_i),
        .nxt_o  (coll_nxt)
    );

    // Next-state and word selection
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        fe_d    = fe_q;
        row_d   = row_q;
        emit    = 1'b0;
        emit_t  = T_HDR;
        emit_pl = '0;
        tr      = decode_tag(st_q, tag, fe_q);
        if (mask_i) begin
            st_d  = S_IDLE;
            cnt_d = '0;
        end else if (bit_en_i) begin
            unique case (st_q)
                S_IDLE: begin
                    if (hdr_hit) begin
                        emit   = 1'b1;
                        emit_t = T_HDR;
                        st_d   = S_L1;
                        cnt_d  = '0;
                    end
                end
                S_HIT_TAIL: begin
                    if (cnt_q == TAIL_LAST) begin
                        emit    = 1'b1;
                        emit_t  = T_HIT;
                        emit_pl = {1'b0, fe_q, row_q, coll_nxt[2*FIELD_W-1:0]};
                        st_d    = S_POST_HIT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                S_RAW: begin
                    if (trl_hit) begin
                        emit   = 1'b1;
                        emit_t = T_TRL;
                        st_d   = S_IDLE;
                        cnt_d  = '0;
                    end else if (cnt_q == RAW_LAST) begin
                        emit    = 1'b1;
                        emit_t  = T_RAW;
                        emit_pl = PL_W'(coll_nxt[RAW_W-1:0]);
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == '0) begin
                        if (bit_i) cnt_d = CNT_W'(1);
                        else       st_d  = S_RAW;
                    end else if (cnt_q == FIELD_LAST) begin
                        cnt_d   = '0;
                        st_d    = tr.nxt;
                        emit    = tr.emit;
                        emit_t  = tr.wtype;
                        emit_pl = tr.pl;
                        if (tr.ld_fe)  fe_d  = tag[NIB_W-1:0];
                        if (tr.ld_row) row_d = tag;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            fe_q  <= '0;
            row_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            fe_q  <= fe_d;
            row_q <= row_d;
        end
    end

    // Output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            word_q  <= '0;
            valid_q <= 1'b0;
            trl_q   <= 1'b0;
        end else begin
            valid_q <= emit && (!almost_full_i || emit_t == T_HDR || emit_t == T_TRL);
            trl_q   <= emit && (emit_t == T_TRL);
            if (emit) word_q <= {emit_t, emit_pl};
        end
    end

    assign word_o            = word_q;
    assign word_valid_o      = valid_q;
    assign trailer_written_o = trl_q;
    assign raw_mode_o        = (st_q == S_RAW);

    a_r9_trl_with_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trailer_written_o |-> (word_valid_o && word_o[31:29] == T_TRL && !raw_mode_o));

    a_r10_af_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv && almost_full_i) |=>
            (!word_valid_o || word_o[31:29] == T_HDR || word_o[31:29] == T_TRL));

    a_r11_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_i |=> (!word_valid_o && !raw_mode_o));

    a_r11_no_bit_no_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_en_i |=> !word_valid_o);

    a_r7_raw_word_in_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_valid_o && word_o[31:29] == T_RAW) |-> raw_mode_o);

    a_r1_hdr_enters_l1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_valid_o && word_o[31:29] == T_HDR) |-> (st_q == S_L1 && $past(st_q) == S_IDLE));

endmodule

// File: tb/psd_decoder_tb_top.sv
module psd_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mask = 1'b0, ben = 1'b0, bin = 1'b0, af = 1'b0;
    logic [31:0] word;
    logic        wval, trl, raw;

    always #4 clk = ~clk;

    psd_decoder dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mask_i(mask), .bit_en_i(ben), .bit_i(bin),
        .almost_full_i(af), .word_o(word), .word_valid_o(wval),
        .trailer_written_o(trl), .raw_mode_o(raw)
    );

    int n_vec = 0, n_fail = 0;
    bit done = 1'b0;

    bit          q_b[$], q_en[$], q_m[$], q_af[$], q_raw[$];
    string       q_tag[$];
    int          e_idx[$];
    logic [31:0] e_w[$];

    bit          raw_on = 1'b0, cur_af = 1'b0;
    int          raw_cnt = 0;
    logic [15:0] rbuf = '0;
    logic [8:0]  win = '0;
    string       cur_tag = "R13";

    localparam logic [31:0] W_HDR = 32'h0000_0000;
    localparam logic [31:0] W_TRL = 32'hE000_0000;

    function automatic logic [31:0] w_l1(input logic [7:0] b); return {3'b001, 21'b0, b}; endfunction
    function automatic logic [31:0] w_bc(input logic [7:0] b); return {3'b010, 21'b0, b}; endfunction
    function automatic logic [31:0] w_fe(input logic [3:0] f); return {3'b011, 25'b0, f}; endfunction
    function automatic logic [31:0] w_hit(input logic [3:0] f, input logic [7:0] r,
                                          input logic [7:0] c, input logic [7:0] t);
        return {3'b100, 1'b0, f, r, c, t};
    endfunction
    function automatic logic [31:0] w_fflag(input logic [3:0] f, input logic [3:0] c);
        return {3'b101, 1'b0, f, 20'b0, c};
    endfunction
    function automatic logic [31:0] w_mflag(input logic [3:0] c); return {3'b101, 1'b1, 24'b0, c}; endfunction
    function automatic logic [31:0] w_raw(input logic [15:0] d); return {3'b110, 13'b0, d}; endfunction

    task automatic chk(input bit ok, input string msg);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic push_bit(input bit b, input bit en, input bit m);
        q_b.push_back(b); q_en.push_back(en); q_m.push_back(m);
        q_af.push_back(cur_af); q_raw.push_back(raw_on); q_tag.push_back(cur_tag);
    endtask

    task automatic expect_w(input logic [31:0] w);
        if (cur_af && w[31:29] != 3'b000 && w[31:29] != 3'b111) return;
        e_idx.push_back(q_b.size() - 1);
        e_w.push_back(w);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) push_bit(v[i], 1'b1, 1'b0);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) push_bit(1'b0, 1'b1, 1'b0);
    endtask

    task automatic stall(input int n);
        for (int i = 0; i < n; i++) push_bit(1'b1, 1'b0, 1'b0);
    endtask

    task automatic masked(input int n);
        raw_on = 1'b0;
        for (int i = 0; i < n; i++) push_bit(i[0] | i[1], 1'b1, 1'b1);
    endtask

    task automatic hdr(input logic [4:0] p, input bit ok);
        send_bits(32'(p), 5);
        if (ok) expect_w(W_HDR);
    endtask

    task automatic field(input logic [7:0] b);
        push_bit(1'b1, 1'b1, 1'b0);
        send_bits(32'(b), 8);
    endtask

    task automatic hit(input logic [3:0] f, input logic [7:0] r, input logic [7:0] c, input logic [7:0] t);
        field(r);
        send_bits(32'({c, t}), 16);
        expect_w(w_hit(f, r, c, t));
    endtask

    task automatic start_raw();
        raw_on = 1'b1; raw_cnt = 0; rbuf = '0; win = '0;
    endtask

    task automatic bad_sync();
        start_raw();
        push_bit(1'b0, 1'b1, 1'b0);
    endtask

    task automatic bad_tag(input logic [7:0] t);
        push_bit(1'b1, 1'b1, 1'b0);
        send_bits(32'(t[7:1]), 7);
        start_raw();
        push_bit(t[0], 1'b1, 1'b0);
    endtask

    task automatic raw_bit(input bit b);
        rbuf = {rbuf[14:0], b};
        win  = {win[7:0], b};
        raw_cnt++;
        if (win == 9'b1_0000_0000) begin
            raw_on = 1'b0;
            push_bit(b, 1'b1, 1'b0);
            expect_w(W_TRL);
        end else begin
            push_bit(b, 1'b1, 1'b0);
            if (raw_cnt == 16) begin
                expect_w(w_raw(rbuf));
                raw_cnt = 0;
            end
        end
    endtask

    task automatic raw_seq(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) raw_bit(v[i]);
    endtask

    task automatic build();
        // event with exact header, chips, hits, error flag
        cur_tag = "R1"; gap(4); hdr(5'b11101, 1'b1);
        cur_tag = "R3"; field(8'h3C); expect_w(w_l1(8'h3C));
        field(8'hA7); expect_w(w_bc(8'hA7));
        cur_tag = "R4"; field(8'hE5); expect_w(w_fe(4'h5));
        cur_tag = "R5"; hit(4'h5, 8'h12, 8'h34, 8'h56);
        hit(4'h5, 8'h01, 8'hFF, 8'h00);
        cur_tag = "R6"; field(8'hF3); expect_w(w_fflag(4'h5, 4'h3));
        field(8'hE2); expect_w(w_fe(4'h2));
        cur_tag = "R5"; hit(4'h2, 8'hCF, 8'h01, 8'h7F);
        cur_tag = "R9"; field(8'h00); expect_w(W_TRL);
        // one-bit-error header, module flag, chip change after hit, end after flag
        cur_tag = "R1"; gap(3); hdr(5'b11001, 1'b1);
        cur_tag = "R3"; field(8'h81); expect_w(w_l1(8'h81));
        field(8'h00); expect_w(w_bc(8'h00));
        cur_tag = "R4"; field(8'hD6); expect_w(w_mflag(4'h6));
        field(8'hE1); expect_w(w_fe(4'h1));
        cur_tag = "R5"; hit(4'h1, 8'h40, 8'h20, 8'h10);
        field(8'hEA); expect_w(w_fe(4'hA));
        cur_tag = "R6"; field(8'hF9); expect_w(w_fflag(4'hA, 4'h9));
        cur_tag = "R9"; field(8'h00); expect_w(W_TRL);
        // two-bit-error header is rejected, then a different one-error header
        cur_tag = "R2"; gap(3); hdr(5'b10001, 1'b0); gap(6);
        cur_tag = "R1"; hdr(5'b11111, 1'b1);
        cur_tag = "R3"; field(8'h11); expect_w(w_l1(8'h11));
        // missing sync bit, raw words, near-miss trailer, exact trailer
        cur_tag = "R7"; bad_sync();
        raw_seq(32'h0000_B6D5, 16); raw_seq(32'h0000_7E3A, 16); raw_seq(32'h1F, 5);
        cur_tag = "R8"; raw_seq(32'b1_0000_0010, 9);
        cur_tag = "R9"; raw_seq(32'b1_0000_0000, 9);
        // end tag where it is not allowed
        cur_tag = "R12"; gap(2); hdr(5'b11101, 1'b1);
        field(8'h22); expect_w(w_l1(8'h22));
        field(8'h33); expect_w(w_bc(8'h33));
        bad_tag(8'h00);
        raw_seq(32'h0000_9C6B, 16); raw_seq(32'b1_0000_0000, 9);
        // almost full drops all but header and trailer
        cur_tag = "R10"; cur_af = 1'b1; gap(2); hdr(5'b11101, 1'b1);
        field(8'h44); expect_w(w_l1(8'h44));
        field(8'h55); expect_w(w_bc(8'h55));
        field(8'hE3); expect_w(w_fe(4'h3));
        hit(4'h3, 8'h0A, 8'h0B, 8'h0C);
        field(8'h00); expect_w(W_TRL);
        cur_af = 1'b0;
        // enable gaps and mask
        cur_tag = "R11"; gap(2);
        send_bits(32'b111, 3); stall(3); send_bits(32'b01, 2); expect_w(W_HDR);
        push_bit(1'b1, 1'b1, 1'b0); stall(2); send_bits(32'h5A, 8); expect_w(w_l1(8'h5A));
        masked(4); gap(4);
        masked(2); push_bit(1'b1, 1'b1, 1'b1); push_bit(1'b1, 1'b1, 1'b1);
        push_bit(1'b1, 1'b1, 1'b1); push_bit(1'b0, 1'b1, 1'b1); push_bit(1'b1, 1'b1, 1'b1);
        gap(3); hdr(5'b11101, 1'b1);
        field(8'h66); expect_w(w_l1(8'h66));
        field(8'h77); expect_w(w_bc(8'h77));
        field(8'hE4); expect_w(w_fe(4'h4));
        hit(4'h4, 8'h99, 8'h88, 8'h77);
        field(8'h00); expect_w(W_TRL);
        gap(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        bit exp_v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        chk(!wval && !trl && !raw, $sformatf("R13 reset: valid=%0b trl=%0b raw=%0b, expected 0 0 0", wval, trl, raw));
        build();
        for (int i = 0; i < q_b.size(); i++) begin
            @(negedge clk);
            bin = q_b[i]; ben = q_en[i]; mask = q_m[i]; af = q_af[i];
            @(posedge clk); #2;
            exp_v = (e_idx.size() > 0) && (e_idx[0] == i);
            if (exp_v) begin
                chk(wval && word == e_w[0] && trl == (e_w[0][31:29] == 3'b111),
                    $sformatf("%s bit %0d: valid=%0b word=%h trl=%0b, expected valid=1 word=%h",
                              q_tag[i], i, wval, word, trl, e_w[0]));
                void'(e_idx.pop_front());
                void'(e_w.pop_front());
            end else begin
                chk(!wval && !trl, $sformatf("%s bit %0d: valid=%0b word=%h trl=%0b, expected no word",
                                             q_tag[i], i, wval, word, trl));
            end
            chk(raw == q_raw[i], $sformatf("%s bit %0d: raw_mode=%0b, expected %0b", q_tag[i], i, raw, q_raw[i]));
        end
        chk(e_idx.size() == 0, $sformatf("R3 end: %0d expected words not seen, expected 0", e_idx.size()));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule